// File: doc/BRIEF.md
# Colour Palette Access Controller

This block holds a 256-entry colour palette and gives a CPU access to it through four byte-wide I/O ports in the legacy video range. One port sets the index for reads, one sets the index for writes, one moves colour data, and one holds a pixel mask. Colour data passes one byte at a time through a temporary triplet register. Each triplet is taken in the order red, green, blue, and each component is 6 bits wide. After every complete triplet the palette index advances by itself, so the CPU can stream consecutive entries without setting the index again.

On the read side, the block fetches a whole entry into the triplet register ahead of time and advances the index before the CPU collects the bytes. On the write side, it collects three bytes and stores them only when the blue byte arrives. A second, independent read port serves the pixel pipeline: the incoming pixel is ANDed with the mask register, and the matching palette entry appears one cycle later.

Top module: `pal_dac_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the pixel mask reads 00h, the state port reads 00h, the index reads 00h and the lookup output is zero.
- R2: The port map is: offset 0 from base 03C6h is the pixel mask, offset 1 (03C7h) is the read index on write and the state on read, offset 2 (03C8h) is the write index (a read returns the current index), and offset 3 (03C9h) is colour data. The mask reads back the full byte that was written to it.
- R3: After a write to 03C8h, three data writes fill red, green and blue from bits 5:0 of each byte. The blue write stores the triplet into palette[index].
- R4: Each stored triplet advances the index by one, and the index wraps from FFh to 00h, so further data writes fill the following entries.
- R5: A write of value N to 03C7h loads palette[N] into the triplet register and sets the index to N+1.
- R6: In read mode, three data reads return red, green and blue, each in bits 5:0 with bits 7:6 zero. The blue read loads the next entry and advances the index, with the same FFh-to-00h wrap.
- R7: The state port returns 03h after a write to the read index and 00h after a write to the write index.
- R8: A write to either index port restarts the component sequence at red, so a partly written triplet is dropped and never stored.
- R9: In read mode, data-port writes are ignored and leave both the triplet and the component position unchanged. In write mode, data-port reads return 00h and have no side effect.
- R10: The lookup output equals palette[pix_in AND mask] one clock after pix_in is applied, packed as {red[17:12], green[11:6], blue[5:0]}.
- R11: When a lookup and a blue-byte store to the same entry land in the same cycle, the lookup returns the old entry. The new entry appears on the next lookup.
- R12: Accesses to addresses outside 03C6h..03C9h change nothing and read as 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | CPU I/O address |
| cpu_wr | input | 1 | CPU write strobe, one cycle per access |
| cpu_rd | input | 1 | CPU read strobe, one cycle per access; side effects take place at the clock edge |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational during cpu_rd |
| pix_in | input | 8 | Pixel value from the display pipeline |
| pix_rgb | output | 18 | Registered palette colour for the masked pixel |

## Verification
Assertions check on every cycle that writing an index port clears the component position, that a write to the read index sets read mode and loads index N+1, that every store advances the index by one, that the mask captures its write data, and that read data never has its top two bits set. Some behaviours only show through the bench's port-level sequences: the red/green/blue ordering over streamed entries, the prefetch contents, the index wrap, ignored data accesses in the wrong mode, the masked pixel lookup and the old-value result when a store and a lookup collide.

// File: rtl/pal_dac_pkg.sv
// Package: shared widths, port selector encoding and colour triplet type
// for the palette access controller. Assumes 6-bit colour components.
package pal_dac_pkg;
    localparam int PAL_COMP_W = 6;
    localparam int PAL_RGB_W  = 3 * PAL_COMP_W;

    typedef enum logic [1:0] {
        PORT_MASK = 2'd0,
        PORT_RIDX = 2'd1,
        PORT_WIDX = 2'd2,
        PORT_DATA = 2'd3
    } port_e;

    typedef struct packed {
        logic [PAL_COMP_W-1:0] r;
        logic [PAL_COMP_W-1:0] g;
        logic [PAL_COMP_W-1:0] b;
    } rgb_t;
endpackage

// File: rtl/pal_dac_decode.sv
// Address decoder: maps a CPU I/O address onto one of four consecutive
// ports starting at BASE_ADDR. Assumes cpu_wr and cpu_rd are not both set;
// if they are, the write wins.
module pal_dac_decode
    import pal_dac_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'h03C6
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    output port_e             sel,
    output logic              wr_en,
    output logic              rd_en
);
    localparam logic [ADDR_W-1:0] BASE     = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] NUM_PORT = ADDR_W'(4);

    logic [ADDR_W-1:0] offs;
    logic              hit;

    // Offset from base and window hit test.
    always_comb begin
        offs  = io_addr - BASE;
        hit   = (offs < NUM_PORT);
        sel   = port_e'(offs[1:0]);
        wr_en = cpu_wr & hit;
        rd_en = cpu_rd & hit & ~cpu_wr;
    end
endmodule

// File: rtl/pal_dac_seq.sv
// Access sequencer: holds the index, the component position, the access
// mode, the triplet register and the pixel mask, and produces store
// requests and CPU read data. Assumes the palette read port is combinational.
module pal_dac_seq
    import pal_dac_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_e             sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [DATA_W-1:0] mask,
    output logic [IDX_W-1:0]  fetch_addr,
    input  rgb_t              fetch_data,
    output logic              st_we,
    output logic [IDX_W-1:0]  st_addr,
    output rgb_t              st_data
);
    localparam logic [1:0]       LAST_COMP = 2'd2;
    localparam logic [IDX_W-1:0] IDX_ONE   = IDX_W'(1);

    logic [IDX_W-1:0]      idx;
    logic [1:0]            comp;
    logic                  rd_mode;
    rgb_t                  trip;
    logic [PAL_COMP_W-1:0] wr_comp;
    logic                  data_wr;
    logic                  data_rd;
    logic [PAL_COMP_W-1:0] rd_comp;

    // Qualified data-port accesses in the matching mode.
    always_comb begin
        wr_comp = cpu_wdata[PAL_COMP_W-1:0];
        data_wr = wr_en && (sel == PORT_DATA) && !rd_mode;
        data_rd = rd_en && (sel == PORT_DATA) && rd_mode;
    end

    // Palette fetch address: the new index on a read-index write, else current index.
    always_comb begin
        if (wr_en && sel == PORT_RIDX) fetch_addr = cpu_wdata[IDX_W-1:0];
        else                           fetch_addr = idx;
    end

    // Store request issued with the blue byte.
    always_comb begin
        st_we   = data_wr && (comp == LAST_COMP);
        st_addr = idx;
        st_data = '{r: trip.r, g: trip.g, b: wr_comp};
    end

    // Index, component counter, mode, triplet and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx     <= '0;
            comp    <= '0;
            rd_mode <= 1'b0;
            trip    <= '0;
            mask    <= '0;
        end else if (wr_en) begin
            unique case (sel)
                PORT_MASK: mask <= cpu_wdata;
                PORT_RIDX: begin
                    trip    <= fetch_data;
                    idx     <= cpu_wdata[IDX_W-1:0] + IDX_ONE;
                    comp    <= '0;
                    rd_mode <= 1'b1;
                end
                PORT_WIDX: begin
                    idx     <= cpu_wdata[IDX_W-1:0];
                    comp    <= '0;
                    rd_mode <= 1'b0;
                end
                PORT_DATA: begin
                    if (data_wr) begin
                        unique case (comp)
                            2'd0:    trip.r <= wr_comp;
                            2'd1:    trip.g <= wr_comp;
                            default: trip.b <= wr_comp;
                        endcase
                        if (comp == LAST_COMP) begin
                            comp <= '0;
                            idx  <= idx + IDX_ONE;
                        end else begin
                            comp <= comp + 2'd1;
                        end
                    end
                end
                default: ;
            endcase
        end else if (data_rd) begin
            if (comp == LAST_COMP) begin
                comp <= '0;
                trip <= fetch_data;
                idx  <= idx + IDX_ONE;
            end else begin
                comp <= comp + 2'd1;
            end
        end
    end

    // Component selected for a data read.
    always_comb begin
        unique case (comp)
            2'd0:    rd_comp = trip.r;
            2'd1:    rd_comp = trip.g;
            default: rd_comp = trip.b;
        endcase
    end

    // CPU read data multiplexer.
    always_comb begin
        cpu_rdata = '0;
        if (rd_en) begin
            unique case (sel)
                PORT_MASK: cpu_rdata = mask;
                PORT_RIDX: cpu_rdata = DATA_W'({rd_mode, rd_mode});
                PORT_WIDX: cpu_rdata = DATA_W'(idx);
                PORT_DATA: cpu_rdata = rd_mode ? DATA_W'(rd_comp) : '0;
                default:   cpu_rdata = '0;
            endcase
        end
    end

    assert_comp_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel == PORT_RIDX || sel == PORT_WIDX)) |=> (comp == 2'd0));

    assert_read_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == PORT_RIDX) |=> rd_mode);

    assert_prefetch_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == PORT_RIDX) |=> (idx == $past(cpu_wdata[IDX_W-1:0]) + IDX_ONE));

    assert_store_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |=> (idx == $past(idx) + IDX_ONE));

    assert_mask_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == PORT_MASK) |=> (mask == $past(cpu_wdata)));

    // R6: colour bytes never carry bits above the component width.
    always_comb begin
        if (rst_n && rd_en && sel == PORT_DATA)
            assert_data_upper_zero_R6: assert (cpu_rdata[DATA_W-1:PAL_COMP_W] == '0);
    end
endmodule

// File: rtl/pal_dac_mem.sv
// Palette storage: one write port, a combinational CPU fetch port, and a
// pixel lookup port whose latency is picked by LOOKUP_LAT (0 or 1).
// Contents are not reset; software is expected to load entries before use.
module pal_dac_mem
    import pal_dac_pkg::*;
#(
    parameter int IDX_W      = 8,
    parameter int LOOKUP_LAT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  rgb_t             wdata,
    input  logic [IDX_W-1:0] fetch_addr,
    output rgb_t             fetch_data,
    input  logic [IDX_W-1:0] pix_addr,
    output rgb_t             pix_data
);
    localparam int DEPTH = 1 << IDX_W;

    rgb_t store [DEPTH];

    // Entry write on a completed triplet.
    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    // CPU prefetch read.
    assign fetch_data = store[fetch_addr];

    generate
        if (LOOKUP_LAT == 0) begin : g_comb_lookup
            assign pix_data = store[pix_addr];
        end else begin : g_reg_lookup
            rgb_t pix_q;
            // Registered lookup; a same-cycle store is seen on the next lookup.
            always_ff @(posedge clk) begin
                if (!rst_n) pix_q <= '0;
                else        pix_q <= store[pix_addr];
            end
            assign pix_data = pix_q;
        end
    endgenerate
endmodule

// File: rtl/pal_dac_ctrl.sv
// Top: palette access controller. Decodes four CPU I/O ports, sequences
// triplet reads and writes with auto-increment, and serves masked pixel
// lookups. Assumes one CPU access per cycle.
module pal_dac_ctrl
    import pal_dac_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          DATA_W     = 8,
    parameter int          IDX_W      = 8,
    parameter int          LOOKUP_LAT = 1,
    parameter logic [15:0] BASE_ADDR  = 16'h03C6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    io_addr,
    input  logic                 cpu_wr,
    input  logic                 cpu_rd,
    input  logic [DATA_W-1:0]    cpu_wdata,
    output logic [DATA_W-1:0]    cpu_rdata,
    input  logic [DATA_W-1:0]    pix_in,
    output logic [PAL_RGB_W-1:0] pix_rgb
);
    port_e            sel;
    logic             wr_en;
    logic             rd_en;
    logic [DATA_W-1:0] mask;
    logic [IDX_W-1:0] fetch_addr;
    rgb_t             fetch_data;
    logic             st_we;
    logic [IDX_W-1:0] st_addr;
    rgb_t             st_data;
    logic [IDX_W-1:0] pix_addr;
    rgb_t             pix_data;

    pal_dac_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
        .io_addr (io_addr),
        .cpu_wr  (cpu_wr),
        .cpu_rd  (cpu_rd),
        .sel     (sel),
        .wr_en   (wr_en),
        .rd_en   (rd_en)
    );

    pal_dac_seq #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .mask       (mask),
        .fetch_addr (fetch_addr),
        .fetch_data (fetch_data),
        .st_we      (st_we),
        .st_addr    (st_addr),
        .st_data    (st_data)
    );

    // Pixel masked before lookup.
    assign pix_addr = IDX_W'(pix_in & mask);

    pal_dac_mem #(.IDX_W(IDX_W), .LOOKUP_LAT(LOOKUP_LAT)) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (st_we),
        .waddr      (st_addr),
        .wdata      (st_data),
        .fetch_addr (fetch_addr),
        .fetch_data (fetch_data),
        .pix_addr   (pix_addr),
        .pix_data   (pix_data)
    );

    assign pix_rgb = pix_data;
endmodule

// File: tb/tb_pal_dac_ctrl.sv
`timescale 1ns/100ps
module tb_pal_dac_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic [7:0]  pix_in = '0;
    logic [17:0] pix_rgb;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pal_dac_ctrl dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .cpu_wr(cpu_wr),
        .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .pix_in(pix_in), .pix_rgb(pix_rgb)
    );

    // Vector: {is_read, req, addr, data}; for reads data is the expected byte.
    localparam int NV = 63;
    localparam logic [28:0] VEC [NV] = '{
        {1'b0,4'd2,16'h03C6,8'hFF}, {1'b1,4'd2,16'h03C6,8'hFF},          // R2 mask
        {1'b0,4'd3,16'h03C8,8'h10},                                      // R3 write entry 10h
        {1'b0,4'd3,16'h03C9,8'h3F}, {1'b0,4'd3,16'h03C9,8'h00}, {1'b0,4'd3,16'h03C9,8'h15},
        {1'b0,4'd4,16'h03C9,8'h01}, {1'b0,4'd4,16'h03C9,8'h02}, {1'b0,4'd4,16'h03C9,8'h03}, // R4 stream 11h
        {1'b1,4'd4,16'h03C8,8'h12},
        {1'b1,4'd7,16'h03C7,8'h00},                                      // R7 write mode
        {1'b0,4'd5,16'h03C7,8'h10}, {1'b1,4'd5,16'h03C8,8'h11},          // R5 prefetch
        {1'b1,4'd7,16'h03C7,8'h03},                                      // R7 read mode
        {1'b1,4'd6,16'h03C9,8'h3F}, {1'b1,4'd6,16'h03C9,8'h00}, {1'b1,4'd6,16'h03C9,8'h15}, // R6
        {1'b1,4'd6,16'h03C9,8'h01}, {1'b1,4'd6,16'h03C9,8'h02}, {1'b1,4'd6,16'h03C9,8'h03},
        {1'b1,4'd6,16'h03C8,8'h13},
        {1'b0,4'd3,16'h03C8,8'h20},                                      // R3 upper bits dropped
        {1'b0,4'd3,16'h03C9,8'hC5}, {1'b0,4'd3,16'h03C9,8'h7A}, {1'b0,4'd3,16'h03C9,8'hFF},
        {1'b0,4'd6,16'h03C7,8'h20},
        {1'b1,4'd6,16'h03C9,8'h05}, {1'b1,4'd6,16'h03C9,8'h3A}, {1'b1,4'd6,16'h03C9,8'h3F},
        {1'b0,4'd8,16'h03C8,8'h30},                                      // R8 partial dropped
        {1'b0,4'd8,16'h03C9,8'h11}, {1'b0,4'd8,16'h03C9,8'h22},
        {1'b0,4'd8,16'h03C8,8'h30},
        {1'b0,4'd8,16'h03C9,8'h01}, {1'b0,4'd8,16'h03C9,8'h02}, {1'b0,4'd8,16'h03C9,8'h03},
        {1'b0,4'd8,16'h03C7,8'h30}, {1'b1,4'd8,16'h03C9,8'h01},
        {1'b0,4'd9,16'h03C9,8'h2A},                                      // R9 write ignored in read mode
        {1'b1,4'd9,16'h03C9,8'h02}, {1'b1,4'd9,16'h03C9,8'h03},
        {1'b0,4'd9,16'h03C8,8'h40}, {1'b1,4'd9,16'h03C9,8'h00}, {1'b1,4'd9,16'h03C8,8'h40}, // R9 read in write mode
        {1'b0,4'd12,16'h03C5,8'h55}, {1'b1,4'd12,16'h03C5,8'h00}, {1'b1,4'd12,16'h03C6,8'hFF}, // R12
        {1'b0,4'd4,16'h03C8,8'hFF},                                      // R4 wrap
        {1'b0,4'd4,16'h03C9,8'h0A}, {1'b0,4'd4,16'h03C9,8'h0B}, {1'b0,4'd4,16'h03C9,8'h0C},
        {1'b0,4'd4,16'h03C9,8'h0D}, {1'b0,4'd4,16'h03C9,8'h0E}, {1'b0,4'd4,16'h03C9,8'h0F},
        {1'b1,4'd4,16'h03C8,8'h01},
        {1'b0,4'd6,16'h03C7,8'hFF},                                      // R6 read wrap
        {1'b1,4'd6,16'h03C9,8'h0A}, {1'b1,4'd6,16'h03C9,8'h0B}, {1'b1,4'd6,16'h03C9,8'h0C},
        {1'b1,4'd6,16'h03C9,8'h0D}, {1'b1,4'd6,16'h03C9,8'h0E}, {1'b1,4'd6,16'h03C9,8'h0F},
        {1'b1,4'd6,16'h03C8,8'h02}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(posedge clk); #1;
        cpu_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; cpu_rd = 1'b1;
        #1 d = cpu_rdata;
        @(posedge clk); #1;
        cpu_rd = 1'b0;
    endtask

    task automatic lookup(input logic [7:0] p, output logic [17:0] c);
        @(negedge clk);
        pix_in = p;
        @(posedge clk); #1;
        c = pix_rgb;
    endtask

    initial begin
        logic [7:0]  rd;
        logic [17:0] c;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        io_read(16'h03C6, rd); check("R1 mask", rd, 8'h00);
        io_read(16'h03C7, rd); check("R1 state", rd, 8'h00);
        io_read(16'h03C8, rd); check("R1 index", rd, 8'h00);
        check("R1 lookup", pix_rgb, 18'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][28]) begin
                io_read(VEC[i][23:8], rd);
                check($sformatf("R%0d vec%0d", VEC[i][27:24], i), rd, VEC[i][7:0]);
            end else begin
                io_write(VEC[i][23:8], VEC[i][7:0]);
            end
        end

        // R10 masked lookups
        lookup(8'h10, c); check("R10 full mask", c, {6'h3F, 6'h00, 6'h15});
        io_write(16'h03C6, 8'h0F);
        lookup(8'h30, c); check("R10 low mask", c, {6'h0D, 6'h0E, 6'h0F});
        io_write(16'h03C6, 8'hF0);
        lookup(8'h3F, c); check("R10 high mask", c, {6'h01, 6'h02, 6'h03});

        // R11 store and lookup in the same cycle
        io_write(16'h03C6, 8'hFF);
        io_write(16'h03C8, 8'h50);
        io_write(16'h03C9, 8'h11); io_write(16'h03C9, 8'h12); io_write(16'h03C9, 8'h13);
        io_write(16'h03C8, 8'h50);
        io_write(16'h03C9, 8'h21); io_write(16'h03C9, 8'h22);
        @(negedge clk);
        io_addr = 16'h03C9; cpu_wdata = 8'h23; cpu_wr = 1'b1; pix_in = 8'h50;
        @(posedge clk); #1;
        cpu_wr = 1'b0;
        check("R11 old entry", pix_rgb, {6'h11, 6'h12, 6'h13});
        @(posedge clk); #1;
        check("R11 new entry", pix_rgb, {6'h21, 6'h22, 6'h23});

        // R1 reset again after activity
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        io_read(16'h03C6, rd); check("R1 mask after reset", rd, 8'h00);
        io_read(16'h03C7, rd); check("R1 state after reset", rd, 8'h00);
        io_read(16'h03C8, rd); check("R1 index after reset", rd, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule